// File: doc/BRIEF.md
# Mode Register Write Engine

This block turns one upstream request into a single DDR4 mode-register write on a memory controller's command port. A request carries a register index, a data word, a command type, a rank select and a flag that enables address mirroring. Once it accepts a request, the engine waits until the controller reports that no mode-register transaction is in flight. It then presents the command word and the data word with a write strobe. In the next cycle it fires the trigger, and it holds off further work until the controller drops its busy flag.

DDR4 modules wire some address and bank lines of the second rank in swapped order. When mirroring is enabled and the second rank is addressed, the engine swaps the two low bank bits of the register index and several pairs of data bits. The controller then drives the pins in the order that rank expects. Completion is reported upstream as a one-cycle done pulse. The controller and the SDRAM are outside the block and appear only as a busy/trigger handshake.

Top module: `mrw_engine`

## Requirements
- R1: After reset, req_ready is 1 and mc_wr, mc_trig and done are all 0.
- R2: After a request is accepted, mc_wr is not asserted until mc_busy has been seen low. mc_wr rises in the cycle after the first cycle in which mc_busy is low.
- R3: Mirroring applies only when req_mirror_en is 1 and req_rank equals 4'b0010. With any other rank, or with the flag at 0, the index and data pass through unchanged.
- R4: When mirroring, bits 0 and 1 of the register index trade places and bit 2 is kept.
- R5: When mirroring, these data bits trade places: 3 with 4, 5 with 6, 7 with 8, and 11 with 13. Bits 0, 1, 2, 9, 10, 12 and every bit above 13 are kept.
- R6: mc_cmd_word carries the command type in bits 3:0, the rank in bits 7:4 and the index in bits 14:12. Bit 31 is the trigger and equals mc_trig. All other bits are 0.
- R7: mc_trig is a one-cycle pulse in the cycle right after the single mc_wr cycle. mc_cmd_word bits 30:0 and mc_data do not change between the two cycles.
- R8: req_ready stays 0 from acceptance until completion. A request held valid during that time is neither taken nor lost. It is accepted at the first edge at which req_ready is 1.
- R9: done is a one-cycle pulse in the cycle after mc_busy is first seen low following the trigger. req_ready is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_index | input | IDX_W (3) | Mode-register index |
| req_data | input | DATA_W (18) | Mode-register data word |
| req_type | input | TYPE_W (4) | Command type |
| req_rank | input | RANK_W (4) | Rank select |
| req_mirror_en | input | 1 | Address mirroring permitted for the second rank |
| mc_busy | input | 1 | Controller has a mode-register transaction in flight |
| mc_wr | output | 1 | Strobe writing mc_cmd_word and mc_data |
| mc_trig | output | 1 | Self-clearing trigger pulse |
| mc_cmd_word | output | 32 | Command word (type, rank, index, trigger) |
| mc_data | output | DATA_W (18) | Data word, mirrored when required |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one write and the acceptance of the next request can fall in the same cycle. req_ready returns high in the very cycle that done is raised. The bench provokes this by holding a second request valid for the whole of a running transaction. It checks that done and req_ready are seen together at that point, and that only one controller write happened before it. It then checks that the held request is taken at the next edge and issued with its own fields intact.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_FREE = 3'd1,
        ST_LOAD      = 3'd2,
        ST_FIRE      = 3'd3,
        ST_WAIT_DONE = 3'd4
    } mrw_state_e;

    // Source bit for a mirrored data bit
    function automatic int data_src(input int b);
        case (b)
            3:       data_src = 4;
            4:       data_src = 3;
            5:       data_src = 6;
            6:       data_src = 5;
            7:       data_src = 8;
            8:       data_src = 7;
            11:      data_src = 13;
            13:      data_src = 11;
            default: data_src = b;
        endcase
    endfunction

    // Source bit for a mirrored index bit (bank bits 0 and 1 trade)
    function automatic int idx_src(input int b);
        case (b)
            0:       idx_src = 1;
            1:       idx_src = 0;
            default: idx_src = b;
        endcase
    endfunction

endpackage

// File: rtl/mrw_mirror.sv
module mrw_mirror #(
    parameter int IDX_W       = 3,
    parameter int DATA_W      = 18,
    parameter int RANK_W      = 4,
    parameter int MIRROR_RANK = 2
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic              en_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [RANK_W-1:0] MRANK = RANK_W'(MIRROR_RANK);

    logic apply;
    assign apply = en_i && (rank_i == MRANK);

    for (genvar b = 0; b < IDX_W; b++) begin : g_idx
        assign idx_o[b] = apply ? idx_i[mrw_pkg::idx_src(b)] : idx_i[b];
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_data
        assign data_o[b] = apply ? data_i[mrw_pkg::data_src(b)] : data_i[b];
    end

endmodule

// File: rtl/mrw_cmd_pack.sv
module mrw_cmd_pack #(
    parameter int IDX_W  = 3,
    parameter int TYPE_W = 4,
    parameter int RANK_W = 4,
    parameter int CMD_W  = 32
) (
    input  logic [TYPE_W-1:0] type_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              trig_i,
    output logic [CMD_W-1:0]  word_o
);
    localparam int RANK_LSB = 4;
    localparam int IDX_LSB  = 12;
    localparam int TRIG_BIT = CMD_W - 1;

    always_comb begin
        word_o = '0;
        word_o[TYPE_W-1:0]                 = type_i;
        word_o[RANK_LSB +: RANK_W]         = rank_i;
        word_o[IDX_LSB +: IDX_W]           = idx_i;
        word_o[TRIG_BIT]                   = trig_i;
    end

endmodule

// File: rtl/mrw_engine.sv
module mrw_engine #(
    parameter int IDX_W       = 3,
    parameter int DATA_W      = 18,
    parameter int TYPE_W      = 4,
    parameter int RANK_W      = 4,
    parameter int MIRROR_RANK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_data,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [RANK_W-1:0] req_rank,
    input  logic              req_mirror_en,
    input  logic              mc_busy,
    output logic              mc_wr,
    output logic              mc_trig,
    output logic [31:0]       mc_cmd_word,
    output logic [DATA_W-1:0] mc_data,
    output logic              done
);
    import mrw_pkg::*;

    localparam int CMD_W = 32;

    typedef struct packed {
        mrw_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [TYPE_W-1:0] typ;
        logic [RANK_W-1:0] rank;
        logic              done;
    } eng_t;

    eng_t r_q, r_d;

    logic [IDX_W-1:0]  mir_idx;
    logic [DATA_W-1:0] mir_data;

    mrw_mirror #(
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W),
        .RANK_W     (RANK_W),
        .MIRROR_RANK(MIRROR_RANK)
    ) i_mirror (
        .idx_i (req_index),
        .data_i(req_data),
        .rank_i(req_rank),
        .en_i  (req_mirror_en),
        .idx_o (mir_idx),
        .data_o(mir_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.idx   = mir_idx;
                    r_d.data  = mir_data;
                    r_d.typ   = req_type;
                    r_d.rank  = req_rank;
                    r_d.state = ST_WAIT_FREE;
                end
            end
            ST_WAIT_FREE: begin
                if (!mc_busy) r_d.state = ST_LOAD;
            end
            ST_LOAD: r_d.state = ST_FIRE;
            ST_FIRE: r_d.state = ST_WAIT_DONE;
            ST_WAIT_DONE: begin
                if (!mc_busy) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, idx: '0, data: '0, typ: '0, rank: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign mc_wr     = (r_q.state == ST_LOAD);
    assign mc_trig   = (r_q.state == ST_FIRE);
    assign mc_data   = r_q.data;
    assign done      = r_q.done;

    mrw_cmd_pack #(
        .IDX_W (IDX_W),
        .TYPE_W(TYPE_W),
        .RANK_W(RANK_W),
        .CMD_W (CMD_W)
    ) i_pack (
        .type_i(r_q.typ),
        .rank_i(r_q.rank),
        .idx_i (r_q.idx),
        .trig_i(mc_trig),
        .word_o(mc_cmd_word)
    );

endmodule

// File: rtl/mrw_engine_chk.sv
module mrw_engine_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mc_busy,
    input logic              mc_wr,
    input logic              mc_trig,
    input logic [31:0]       mc_cmd_word,
    input logic [DATA_W-1:0] mc_data,
    input logic              done
);
    // R2
    wr_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_wr |-> !$past(mc_busy));

    // R7
    trig_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_trig |-> $past(mc_wr));

    // R7
    fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_trig |-> ($stable(mc_cmd_word[30:0]) && $stable(mc_data)));

    // R8
    busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_trig |=> !req_ready);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

bind mrw_engine mrw_engine_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mc_busy    (mc_busy),
    .mc_wr      (mc_wr),
    .mc_trig    (mc_trig),
    .mc_cmd_word(mc_cmd_word),
    .mc_data    (mc_data),
    .done       (done)
);

// File: tb/test_mrw_engine.sv
module test_mrw_engine;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 18;
    localparam int TYPE_W = 4;
    localparam int RANK_W = 4;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [IDX_W-1:0]  req_index = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [TYPE_W-1:0] req_type = '0;
    logic [RANK_W-1:0] req_rank = '0;
    logic req_mirror_en = 1'b0;
    logic mc_busy;
    logic mc_wr, mc_trig, done;
    logic [31:0] mc_cmd_word;
    logic [DATA_W-1:0] mc_data;

    always #2.5 clk = ~clk;

    mrw_engine i_mrw_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_data(req_data), .req_type(req_type),
        .req_rank(req_rank), .req_mirror_en(req_mirror_en), .mc_busy(mc_busy),
        .mc_wr(mc_wr), .mc_trig(mc_trig), .mc_cmd_word(mc_cmd_word),
        .mc_data(mc_data), .done(done)
    );

    // Controller model: busy rises on the edge that samples the trigger
    int busy_cnt;
    logic ext_busy = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (mc_trig) busy_cnt <= LAT;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    assign mc_busy = (busy_cnt != 0) || ext_busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor sampling away from the active edge
    int wr_count = 0, trig_count = 0, done_count = 0;
    int wr_cyc = 0, trig_cyc = 0;
    logic [31:0] wr_word, trig_word;
    logic [DATA_W-1:0] wr_data_s, trig_data;
    always @(negedge clk) begin
        if (mc_wr) begin
            wr_count++; wr_cyc = cyc; wr_word = mc_cmd_word; wr_data_s = mc_data;
        end
        if (mc_trig) begin
            trig_count++; trig_cyc = cyc; trig_word = mc_cmd_word; trig_data = mc_data;
        end
        if (done) done_count++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_data(input logic [DATA_W-1:0] d,
                                                   input logic [RANK_W-1:0] rk, input logic en);
        logic [DATA_W-1:0] r;
        r = d;
        if (en && rk == 4'b0010) begin
            r[3] = d[4];  r[4] = d[3];
            r[5] = d[6];  r[6] = d[5];
            r[7] = d[8];  r[8] = d[7];
            r[11] = d[13]; r[13] = d[11];
        end
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] exp_idx(input logic [IDX_W-1:0] i,
                                                 input logic [RANK_W-1:0] rk, input logic en);
        if (en && rk == 4'b0010) return {i[2], i[0], i[1]};
        return i;
    endfunction

    function automatic logic [31:0] exp_word(input logic [IDX_W-1:0] i, input logic [RANK_W-1:0] rk,
                                             input logic [TYPE_W-1:0] t);
        return {17'b0, i, 4'b0, rk, t};
    endfunction

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic issue(input logic [IDX_W-1:0] i, input logic [DATA_W-1:0] d,
                         input logic [TYPE_W-1:0] t, input logic [RANK_W-1:0] rk, input logic en);
        while (!req_ready) @(negedge clk);
        req_index = i; req_data = d; req_type = t; req_rank = rk; req_mirror_en = en;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic judge(input string tag, input logic [IDX_W-1:0] i, input logic [DATA_W-1:0] d,
                         input logic [TYPE_W-1:0] t, input logic [RANK_W-1:0] rk, input logic en);
        logic [IDX_W-1:0] ei;
        ei = exp_idx(i, rk, en);
        check({tag, " word"}, 64'(wr_word), 64'(exp_word(ei, rk, t)));
        check({tag, " data"}, 64'(wr_data_s), 64'(exp_data(d, rk, en)));
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 wr/trig/done", 64'({mc_wr, mc_trig, done}), 64'd0);
    endtask

    task automatic t_plain();
        int w0;
        w0 = wr_count;
        issue(3'd5, 18'h3FA5C, 4'h0, 4'b0001, 1'b1);
        wait_done();
        check("R3 rank1 one write", 64'(wr_count - w0), 64'd1);
        judge("R3 R6 rank1", 3'd5, 18'h3FA5C, 4'h0, 4'b0001, 1'b1);
        check("R7 trig next cycle", 64'(trig_cyc - wr_cyc), 64'd1);
        check("R6 R7 trig word", 64'(trig_word), 64'({1'b1, wr_word[30:0]}));
        check("R7 trig data", 64'(trig_data), 64'(wr_data_s));
        check("R9 done with ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        check("R9 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_mirror();
        issue(3'd1, 18'h02A8, 4'h3, 4'b0010, 1'b1);
        wait_done();
        judge("R4 R5 mirror a", 3'd1, 18'h02A8, 4'h3, 4'b0010, 1'b1);
        check("R4 idx 1->2", 64'(wr_word[14:12]), 64'd2);
        issue(3'd6, 18'h2C918, 4'h5, 4'b0010, 1'b1);
        wait_done();
        judge("R4 R5 mirror b", 3'd6, 18'h2C918, 4'h5, 4'b0010, 1'b1);
        check("R5 bit11->13", 64'(wr_data_s[13]), 64'd1);
        issue(3'd6, 18'h3FFFF, 4'h1, 4'b0010, 1'b1);
        wait_done();
        check("R5 all ones kept", 64'(wr_data_s), 64'h3FFFF);
    endtask

    task automatic t_no_mirror();
        issue(3'd2, 18'h0A18, 4'h2, 4'b0010, 1'b0);
        wait_done();
        judge("R3 flag off", 3'd2, 18'h0A18, 4'h2, 4'b0010, 1'b0);
        check("R3 flag off raw", 64'(wr_data_s), 64'h0A18);
        issue(3'd1, 18'h0A18, 4'h2, 4'b0011, 1'b1);
        wait_done();
        check("R3 rank3 raw data", 64'(wr_data_s), 64'h0A18);
        check("R3 rank3 raw idx", 64'(wr_word[14:12]), 64'd1);
    endtask

    task automatic t_wait_busy();
        int w0, rel;
        ext_busy = 1'b1;
        w0 = wr_count;
        issue(3'd4, 18'h00155, 4'h7, 4'b0001, 1'b0);
        repeat (6) @(negedge clk);
        check("R2 no write while busy", 64'(wr_count - w0), 64'd0);
        check("R8 ready low while pending", 64'(req_ready), 64'd0);
        ext_busy = 1'b0;
        rel = cyc;
        @(negedge clk);
        @(negedge clk);
        check("R2 write after free", 64'(wr_count - w0), 64'd1);
        check("R2 write timing", 64'(wr_cyc), 64'(rel + 1));
        wait_done();
        judge("R2 R6 after wait", 3'd4, 18'h00155, 4'h7, 4'b0001, 1'b0);
    endtask

    task automatic t_holdoff();
        int w0, low_n;
        while (!req_ready) @(negedge clk);
        w0 = wr_count;
        req_index = 3'd3; req_data = 18'h01234; req_type = 4'h1; req_rank = 4'b0001;
        req_mirror_en = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_index = 3'd0; req_data = 18'h00818; req_type = 4'h9; req_rank = 4'b0010;
        req_mirror_en = 1'b1;
        low_n = 0;
        while (!req_ready) begin
            low_n++;
            @(negedge clk);
        end
        check("R8 ready low during transaction", 64'(low_n >= 5), 64'd1);
        check("R9 done with ready (same cycle)", 64'(done), 64'd1);
        check("R8 one write before done", 64'(wr_count - w0), 64'd1);
        judge("R8 first request", 3'd3, 18'h01234, 4'h1, 4'b0001, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        check("R8 held request issued", 64'(wr_count - w0), 64'd2);
        judge("R8 R5 held request", 3'd0, 18'h00818, 4'h9, 4'b0010, 1'b1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_mirror();
        t_no_mirror();
        t_wait_busy();
        t_holdoff();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule